// File: doc/BRIEF.md
# Sprite attribute access window

This block sits between a byte-wide host bus and an 8 KB RAM. Host addresses are 13 bits. Nearly every address goes straight through to the same RAM byte. A small group of register addresses at the top of the window is handled differently. These registers let software reach a sprite attribute table through an index register and do not require it to compute table addresses itself.

Two registers select the target. The first picks the table base, which is one of two 1 KB-aligned areas. The second holds a 7-bit record index. Four alias addresses then map onto the 4-byte record chosen by the index. A fifth alias address maps onto a packed table of 2-bit fields that lies 0x200 bytes above the base. A write to that fifth address inserts two bits into a byte with a read-modify-write sequence. During that sequence the block holds off the host with a wait signal.

After reset, the block reloads the base and index from the copies of the two register bytes held in RAM. Software state therefore survives a reset of this block alone.

Top module: `sprwin_top`

## Requirements
- R1: An access to any address outside 0x1FF0..0x1FF4 reads or writes the RAM byte at that same address. This includes 0x1FF5 and 0x1FF6.
- R2: A write to 0x1FF5 selects base 0x1800 when data bit 0 is 1 and base 0x1C00 when it is 0. The other data bits do not affect the base. The byte is also stored at RAM 0x1FF5.
- R3: A write to 0x1FF6 sets the index to data[6:0]. The field shift becomes twice data[1:0]. The byte is also stored at RAM 0x1FF6.
- R4: A read or write of 0x1FF0+k, for k = 0..3, targets RAM at base + 4*index + k.
- R5: A read of 0x1FF4 returns the RAM byte at base + 0x200 + (index >> 2).
- R6: A write to 0x1FF4 replaces bits [shift+1:shift] of the byte at base + 0x200 + (index >> 2) with data[1:0] and keeps all other bits. wait_o is high in exactly the one cycle after the write is accepted, and the write-back to RAM happens in that cycle.
- R7: After reset is released, wait_o stays high for 3 cycles while the block reads RAM 0x1FF5 and 0x1FF6. The base, index and shift are loaded as if those bytes had been written.
- R8: A request is accepted in a cycle when req_i is high and wait_o is low. An accepted read gives rvalid_o high, with the data on rdata_o, in the next cycle. Writes never raise rvalid_o.
- R9: A request presented while wait_o is high has no effect on RAM or on the block's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 13 | Host byte address within the window |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after acceptance |
| wait_o | output | 1 | Block busy; requests are not accepted |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 13 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the enable |

## Verification
The bench first tests pass-through with a strided address sweep. Writes and reads use data that depends on the address, so an aliasing or dropped address bit shows up as a mismatch. Then, for both base settings and every index from 0 to 127, it writes and reads all four record bytes. It also inserts a field value through the packed-field address. Each index hits a different pair position, so all four pairs of every field byte are overwritten in turn, and the check catches a wrong shift, a wrong byte, or lost neighbouring bits. Setting index bit 7 on odd indices and writing stray high bits to the base register shows whether the masking is right. A reset preceded by preloaded register copies, together with a request issued during the write-back cycle, covers the reload and the request-ignoring behaviour.

// File: rtl/sprwin_pkg.sv
package sprwin_pkg;
  localparam int WIN_AW = 13;
  localparam int DATA_W = 8;

  localparam logic [WIN_AW-1:0] A_REC0  = 13'h1FF0;
  localparam logic [WIN_AW-1:0] A_REC3  = 13'h1FF3;
  localparam logic [WIN_AW-1:0] A_FIELD = 13'h1FF4;
  localparam logic [WIN_AW-1:0] A_BASE  = 13'h1FF5;
  localparam logic [WIN_AW-1:0] A_INDEX = 13'h1FF6;
  localparam logic [WIN_AW-1:0] BASE_SET   = 13'h1800;
  localparam logic [WIN_AW-1:0] BASE_CLR   = 13'h1C00;
  localparam logic [WIN_AW-1:0] FIELD_OFFS = 13'h0200;

  typedef enum logic [2:0] {
    ST_LD_BASE,
    ST_LD_INDEX,
    ST_APPLY,
    ST_IDLE,
    ST_WRBACK
  } sw_state_e;
endpackage

// File: rtl/sprwin_map.sv
module sprwin_map
  import sprwin_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [WIN_AW-1:0] addr_i,
  input  logic              base_sel_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [WIN_AW-1:0] ram_addr_o,
  output logic              is_field_o,
  output logic              is_base_o,
  output logic              is_index_o
);
  logic [WIN_AW-1:0] base;
  logic [WIN_AW-1:0] rec_addr;
  logic [WIN_AW-1:0] fld_addr;
  logic              is_rec;

  assign base     = base_sel_i ? BASE_SET : BASE_CLR;
  assign rec_addr = base + WIN_AW'({index_i, 2'b00}) + WIN_AW'(addr_i[1:0]);
  assign fld_addr = base + FIELD_OFFS + WIN_AW'(index_i >> 2);

  assign is_rec     = (addr_i >= A_REC0) && (addr_i <= A_REC3);
  assign is_field_o = (addr_i == A_FIELD);
  assign is_base_o  = (addr_i == A_BASE);
  assign is_index_o = (addr_i == A_INDEX);

  always_comb begin
    if (is_rec)          ram_addr_o = rec_addr;
    else if (is_field_o) ram_addr_o = fld_addr;
    else                 ram_addr_o = addr_i;
  end
endmodule

// File: rtl/sprwin_merge.sv
module sprwin_merge
  import sprwin_pkg::*;
#(
  parameter int FW = 2
) (
  input  logic [DATA_W-1:0]               old_i,
  input  logic [FW-1:0]                   bits_i,
  input  logic [$clog2(DATA_W/FW)-1:0]    slot_i,
  output logic [DATA_W-1:0]               new_o
);
  localparam int SLOTS = DATA_W / FW;
  localparam int SW    = $clog2(SLOTS);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign new_o[s*FW +: FW] = (slot_i == SW'(s)) ? bits_i : old_i[s*FW +: FW];
  end
endmodule

// File: rtl/sprwin_top.sv
module sprwin_top
  import sprwin_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [12:0]       addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              wait_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [12:0]       ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i
);
  localparam int FW = 2;
  localparam int SW = $clog2(DATA_W / FW);

  sw_state_e         state_q, state_d;
  logic              base_sel_q;
  logic [IDX_W-1:0]  index_q;
  logic [WIN_AW-1:0] wb_addr_q;
  logic [FW-1:0]     wb_bits_q;
  logic              rvalid_q;

  logic [WIN_AW-1:0] map_addr;
  logic              is_field, is_base, is_index;
  logic              accept;
  logic [DATA_W-1:0] merged;

  sprwin_map #(.IDX_W(IDX_W)) u_map (
    .addr_i     (addr_i),
    .base_sel_i (base_sel_q),
    .index_i    (index_q),
    .ram_addr_o (map_addr),
    .is_field_o (is_field),
    .is_base_o  (is_base),
    .is_index_o (is_index)
  );

  // field shift is twice the low index bits, so the slot is index[1:0]
  sprwin_merge #(.FW(FW)) u_merge (
    .old_i  (ram_rdata_i),
    .bits_i (wb_bits_q),
    .slot_i (index_q[SW-1:0]),
    .new_o  (merged)
  );

  assign accept   = req_i && (state_q == ST_IDLE);
  assign wait_o   = (state_q != ST_IDLE);
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rvalid_q ? ram_rdata_i : '0;

  always_comb begin
    state_d     = state_q;
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = map_addr;
    ram_wdata_o = wdata_i;
    unique case (state_q)
      ST_LD_BASE: begin
        ram_en_o   = 1'b1;
        ram_addr_o = A_BASE;
        state_d    = ST_LD_INDEX;
      end
      ST_LD_INDEX: begin
        ram_en_o   = 1'b1;
        ram_addr_o = A_INDEX;
        state_d    = ST_APPLY;
      end
      ST_APPLY: state_d = ST_IDLE;
      ST_IDLE: begin
        ram_en_o = accept;
        ram_we_o = accept && we_i && !is_field;
        if (accept && we_i && is_field) state_d = ST_WRBACK;
      end
      ST_WRBACK: begin
        ram_en_o    = 1'b1;
        ram_we_o    = 1'b1;
        ram_addr_o  = wb_addr_q;
        ram_wdata_o = merged;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LD_BASE;
      base_sel_q <= 1'b0;
      index_q    <= '0;
      wb_addr_q  <= '0;
      wb_bits_q  <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= accept && !we_i;
      if (state_q == ST_LD_INDEX) base_sel_q <= ram_rdata_i[0];
      if (state_q == ST_APPLY)    index_q    <= ram_rdata_i[IDX_W-1:0];
      if (accept && we_i) begin
        if (is_base)  base_sel_q <= wdata_i[0];
        if (is_index) index_q    <= wdata_i[IDX_W-1:0];
        if (is_field) begin
          wb_addr_q <= map_addr;
          wb_bits_q <= wdata_i[FW-1:0];
        end
      end
    end
  end

  logic [DATA_W-1:0] keep_mask;
  assign keep_mask = ~(DATA_W'(2'b11) << {index_q[SW-1:0], 1'b0});

  AST_REG_HOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && state_q == ST_IDLE) |-> !((ram_addr_o >= A_REC0) && (ram_addr_o <= A_FIELD))); // R4
  AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o && !we_i) |=> rvalid_o); // R8
  AST_NO_WRITE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o && we_i) |=> !rvalid_o); // R8
  AST_WB_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRBACK) |-> (ram_we_o && ram_addr_o == $past(ram_addr_o))); // R6
  AST_WB_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRBACK) |-> (((ram_wdata_o ^ ram_rdata_i) & keep_mask) == '0)); // R6
  AST_WAIT_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRBACK) |=> !wait_o); // R6
  AST_BUSY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && state_q != ST_WRBACK) |-> !ram_we_o); // R9
endmodule

// File: tb/sprwin_top_test.sv
`timescale 1ns/1ps
module sprwin_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, wait_s;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_q = '0;

  logic [7:0]  ram [0:8191];
  logic [7:0]  mdl [0:8191];
  logic        m_base;
  logic [6:0]  m_idx;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sprwin_top uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .wait_o(wait_s),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_q)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      ram_q <= ram[ram_addr];
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  function automatic logic [12:0] eff(input logic [12:0] w);
    int b;
    b = m_base ? 'h1800 : 'h1C00;
    if (w >= 13'h1FF0 && w <= 13'h1FF3) return 13'(b + int'(m_idx) * 4 + int'(w - 13'h1FF0));
    if (w == 13'h1FF4) return 13'(b + 'h200 + int'(m_idx) / 4);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [12:0] a, input logic [7:0] d);
    logic [12:0] ea;
    int sh;
    ea = eff(a);
    if (a == 13'h1FF4) begin
      sh = int'(m_idx[1:0]) * 2;
      mdl[ea][sh +: 2] = d[1:0];
    end else mdl[ea] = d;
    if (a == 13'h1FF5) m_base = d[0];
    if (a == 13'h1FF6) m_idx = d[6:0];
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
    logic [12:0] ea;
    ea = eff(a);
    @(negedge clk);
    while (wait_s) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    while (wait_s) @(negedge clk);
    model_wr(a, d);
    chk(ram[ea] === mdl[ea], tag, int'(ram[ea]), int'(mdl[ea]));
  endtask

  task automatic rd(input logic [12:0] a, input string tag);
    logic [7:0] exp;
    exp = mdl[eff(a)];
    @(negedge clk);
    while (wait_s) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    chk(rvalid === 1'b1 && rdata === exp, tag, int'({rvalid, rdata}), int'({1'b1, exp}));
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < 8192; a++) begin
      ram[a] = pat(a);
      mdl[a] = pat(a);
    end
    ram[13'h1FF5] = 8'h01; mdl[13'h1FF5] = 8'h01;
    ram[13'h1FF6] = 8'h85; mdl[13'h1FF6] = 8'h85;
    m_base = 1'b1; m_idx = 7'd5;

    repeat (3) @(negedge clk);
    chk(wait_s === 1'b1 && rvalid === 1'b0, "R7 reset state", int'({wait_s, rvalid}), 2);
    rst_n = 1'b1;
    n = 0;
    while (wait_s && n < 10) begin n++; @(negedge clk); end
    chk(n == 3, "R7 init wait cycles", n, 3);
    for (int k = 0; k < 5; k++) rd(13'(13'h1FF0 + k), "R7 reloaded base/index");

    // R1 strided pass-through sweep
    for (int a = 3; a < 8192; a += 37) begin
      if (a >= 'h1FF0 && a <= 'h1FF6) continue;
      wr(13'(a), 8'(a ^ 'h5A), "R1 pass write");
      rd(13'(a), "R1 pass read");
    end

    for (int b = 0; b < 2; b++) begin
      wr(13'h1FF5, b[0] ? 8'h03 : 8'hFE, "R2 base store");
      rd(13'h1FF5, "R2 base readback");
      for (int i = 0; i < 128; i++) begin
        wr(13'h1FF6, 8'(i | (i[0] ? 'h80 : 0)), "R3 index store");
        for (int k = 0; k < 4; k++) begin
          logic [12:0] ea;
          ea = 13'((b ? 'h1800 : 'h1C00) + i * 4 + k);
          wr(13'(13'h1FF0 + k), 8'((i * 4 + k) ^ (b ? 'hB3 : 'h33)), "R4 record write");
          chk(ram[ea] === 8'((i * 4 + k) ^ (b ? 'hB3 : 'h33)), "R4 record position",
              int'(ram[ea]), (i * 4 + k) ^ (b ? 'hB3 : 'h33));
        end
        for (int k = 0; k < 4; k++) rd(13'(13'h1FF0 + k), "R4 record read");
        wr(13'h1FF4, 8'('hA4 ^ i), "R6 field insert");
        rd(13'h1FF4, "R5 field read");
      end
      rd(13'h1FF6, "R3 index readback");
    end

    // R6 one wait cycle, R9 request during wait ignored
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h1FF4; wdata = 8'h02;
    @(negedge clk);
    chk(wait_s === 1'b1, "R6 wait after field write", int'(wait_s), 1);
    model_wr(13'h1FF4, 8'h02);
    addr = 13'h0100; wdata = 8'hAA;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(wait_s === 1'b0, "R6 wait one cycle", int'(wait_s), 0);
    chk(ram[13'h0100] === mdl[13'h0100], "R9 ignored during wait",
        int'(ram[13'h0100]), int'(mdl[13'h0100]));
    chk(ram[eff(13'h1FF4)] === mdl[eff(13'h1FF4)], "R6 field after wait",
        int'(ram[eff(13'h1FF4)]), int'(mdl[eff(13'h1FF4)]));
    rd(13'h0100, "R9 readback");

    // R8 write gives no valid
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h0200; wdata = 8'h11;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_wr(13'h0200, 8'h11);
    chk(rvalid === 1'b0, "R8 no valid after write", int'(rvalid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule